// File: doc/BRIEF.md
# Battery Thermistor Charge/Discharge Permission Monitor

This block decides whether battery temperature permits charging and whether it permits discharging. Each measurement comes in as a pair of ADC codes read from a thermistor divider. The first code is taken while the divider is driven from the high reference. The second is taken while it is driven from analog ground. The block subtracts the ground-step code from the high-step code, which removes the amplifier and converter offset. The result is a signed value that tracks thermistor resistance. For an NTC part, a larger value means colder.

The value is compared against thresholds that firmware has already converted to codes. The charge permission uses hysteresis, with separate stop and restart limits at both the cold end and the hot end. The discharge permission uses a plain window with one limit at each end and no memory. Each measurement pair arrives as one transfer on a valid/ready stream. The block never applies back-pressure: `s_ready` is high at all times outside reset, so a new pair can be sent every clock cycle. Both permissions are plain level outputs.

Top module: `thermal_window_mon`

## Requirements
- R1: The measured value is the high-reference code minus the ground code, both taken as unsigned CODE_W-bit values. The difference is kept as a signed CODE_W+1-bit number, so a negative difference is compared as below every threshold, which reads as hottest.
- R2: With charging permitted, a value at or above `thr_chg_cold_stop` clears `chg_ok`.
- R3: With charging permitted, a value at or below `thr_chg_hot_stop` clears `chg_ok`. A value strictly between the two stop limits keeps `chg_ok` at 1.
- R4: With charging not permitted, `chg_ok` returns to 1 only for a value strictly above `thr_chg_hot_go` and strictly below `thr_chg_cold_go`. Any other value keeps it at 0.
- R5: `dis_ok` is 1 exactly when the latest value is strictly above `thr_dis_hot_stop` and strictly below `thr_dis_cold_stop`. It depends only on that one sample.
- R6: A pair accepted at clock edge N affects the outputs from edge N+1 onward. Both outputs hold their values in every cycle that has no accepted pair, whatever the data inputs carry.
- R7: While reset is held and after its release, `chg_ok` and `dis_ok` are 0 until the first sample is evaluated.
- R8: `s_ready` is 1 whenever reset is not asserted. Pairs sent on consecutive cycles are each evaluated, in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Measurement pair valid |
| s_ready | output | 1 | Always ready outside reset |
| s_ref_hi_code | input | CODE_W | ADC code with divider on high reference |
| s_ref_gnd_code | input | CODE_W | ADC code with divider on analog ground |
| thr_chg_cold_stop | input | CODE_W | Charge cold stop limit |
| thr_chg_cold_go | input | CODE_W | Charge cold restart limit |
| thr_chg_hot_go | input | CODE_W | Charge hot restart limit |
| thr_chg_hot_stop | input | CODE_W | Charge hot stop limit |
| thr_dis_cold_stop | input | CODE_W | Discharge cold limit |
| thr_dis_hot_stop | input | CODE_W | Discharge hot limit |
| chg_ok | output | 1 | Charging permitted |
| dis_ok | output | 1 | Discharging permitted |

## Verification
Each pair passes through two registers: the subtraction stage and then the flag stage. A pair driven before rising edge N therefore shows on `chg_ok` and `dis_ok` just after edge N+1. For single samples, the bench drives on a falling edge and checks two falling edges later. For back-to-back streams, it checks the result of sample k at the falling edge where sample k+2 is driven. Idle cycles with changing data are followed by the same two-edge wait before the outputs are compared with their previous values.

// File: rtl/tmon_pkg.sv
package tmon_pkg;
  typedef enum logic {
    WIN_BLOCKED = 1'b0,
    WIN_ALLOWED = 1'b1
  } win_state_e;
endpackage

// File: rtl/tmon_diff.sv
module tmon_diff #(
  parameter int CODE_W = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     take,
  input  logic [CODE_W-1:0]        hi_code,
  input  logic [CODE_W-1:0]        gnd_code,
  output logic                     val_vld,
  output logic signed [CODE_W:0]   val
);
  localparam int SW = CODE_W + 1;

  logic signed [SW-1:0] hi_s, gnd_s;
  assign hi_s  = $signed({1'b0, hi_code});
  assign gnd_s = $signed({1'b0, gnd_code});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      val_vld <= 1'b0;
      val     <= '0;
    end else begin
      val_vld <= take;
      if (take) val <= hi_s - gnd_s;
    end
  end
endmodule

// File: rtl/tmon_window.sv
module tmon_window
  import tmon_pkg::*;
#(
  parameter int CODE_W = 12,
  parameter bit HYST   = 1'b1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   upd,
  input  logic signed [CODE_W:0] val,
  input  logic [CODE_W-1:0]      cold_stop,
  input  logic [CODE_W-1:0]      hot_stop,
  input  logic [CODE_W-1:0]      cold_go,
  input  logic [CODE_W-1:0]      hot_go,
  output logic                   ok
);
  localparam int SW = CODE_W + 1;

  logic signed [SW-1:0] cs_s, hs_s, cg_s, hg_s;
  logic at_cold, at_hot, in_go;

  assign cs_s = $signed({1'b0, cold_stop});
  assign hs_s = $signed({1'b0, hot_stop});
  assign cg_s = $signed({1'b0, cold_go});
  assign hg_s = $signed({1'b0, hot_go});

  // Larger code means colder for a negative-coefficient thermistor
  assign at_cold = (val >= cs_s);
  assign at_hot  = (val <= hs_s);
  assign in_go   = (val < cg_s) && (val > hg_s);

  win_state_e st_q, st_d;

  generate
    if (HYST) begin : g_hyst
      always_comb begin
        st_d = st_q;
        if (upd) begin
          if (st_q == WIN_ALLOWED) begin
            if (at_cold || at_hot) st_d = WIN_BLOCKED;
          end else begin
            if (in_go) st_d = WIN_ALLOWED;
          end
        end
      end
    end else begin : g_plain
      // Go limits are tied to the stop limits by the parent; both must pass
      always_comb begin
        st_d = st_q;
        if (upd) st_d = (!(at_cold || at_hot) && in_go) ? WIN_ALLOWED : WIN_BLOCKED;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= WIN_BLOCKED;
    else        st_q <= st_d;
  end

  assign ok = (st_q == WIN_ALLOWED);
endmodule

// File: rtl/thermal_window_mon.sv
module thermal_window_mon #(
  parameter int CODE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [CODE_W-1:0] s_ref_hi_code,
  input  logic [CODE_W-1:0] s_ref_gnd_code,
  input  logic [CODE_W-1:0] thr_chg_cold_stop,
  input  logic [CODE_W-1:0] thr_chg_cold_go,
  input  logic [CODE_W-1:0] thr_chg_hot_go,
  input  logic [CODE_W-1:0] thr_chg_hot_stop,
  input  logic [CODE_W-1:0] thr_dis_cold_stop,
  input  logic [CODE_W-1:0] thr_dis_hot_stop,
  output logic              chg_ok,
  output logic              dis_ok
);
  logic                   d_vld;
  logic signed [CODE_W:0] d_val;
  logic                   take;

  assign s_ready = rst_n;
  assign take    = s_valid && s_ready;

  tmon_diff #(.CODE_W(CODE_W)) u_diff (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (take),
    .hi_code  (s_ref_hi_code),
    .gnd_code (s_ref_gnd_code),
    .val_vld  (d_vld),
    .val      (d_val)
  );

  tmon_window #(.CODE_W(CODE_W), .HYST(1'b1)) u_chg (
    .clk       (clk),
    .rst_n     (rst_n),
    .upd       (d_vld),
    .val       (d_val),
    .cold_stop (thr_chg_cold_stop),
    .hot_stop  (thr_chg_hot_stop),
    .cold_go   (thr_chg_cold_go),
    .hot_go    (thr_chg_hot_go),
    .ok        (chg_ok)
  );

  tmon_window #(.CODE_W(CODE_W), .HYST(1'b0)) u_dis (
    .clk       (clk),
    .rst_n     (rst_n),
    .upd       (d_vld),
    .val       (d_val),
    .cold_stop (thr_dis_cold_stop),
    .hot_stop  (thr_dis_hot_stop),
    .cold_go   (thr_dis_cold_stop),
    .hot_go    (thr_dis_hot_stop),
    .ok        (dis_ok)
  );
endmodule

// File: rtl/tmon_chk.sv
module tmon_chk #(
  parameter int CODE_W = 12
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   s_valid,
  input logic                   s_ready,
  input logic [CODE_W-1:0]      s_ref_hi_code,
  input logic [CODE_W-1:0]      s_ref_gnd_code,
  input logic [CODE_W-1:0]      thr_chg_cold_stop,
  input logic [CODE_W-1:0]      thr_chg_cold_go,
  input logic [CODE_W-1:0]      thr_chg_hot_go,
  input logic [CODE_W-1:0]      thr_chg_hot_stop,
  input logic [CODE_W-1:0]      thr_dis_cold_stop,
  input logic [CODE_W-1:0]      thr_dis_hot_stop,
  input logic                   d_vld,
  input logic signed [CODE_W:0] d_val,
  input logic                   chg_ok,
  input logic                   dis_ok
);
  AST_DIFF_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready && (s_ref_hi_code < s_ref_gnd_code)) |=> (d_vld && d_val < 0)); // R1
  AST_CHG_COLD_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (d_vld && chg_ok && d_val >= $signed({1'b0, thr_chg_cold_stop})) |=> !chg_ok); // R2
  AST_CHG_HOT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (d_vld && chg_ok && d_val <= $signed({1'b0, thr_chg_hot_stop})) |=> !chg_ok); // R3
  AST_CHG_NO_EARLY_GO: assert property (@(posedge clk) disable iff (!rst_n)
    (d_vld && !chg_ok && d_val >= $signed({1'b0, thr_chg_cold_go})) |=> !chg_ok); // R4
  AST_DIS_COLD_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (d_vld && d_val >= $signed({1'b0, thr_dis_cold_stop})) |=> !dis_ok); // R5
  AST_DIS_HOT_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (d_vld && d_val <= $signed({1'b0, thr_dis_hot_stop})) |=> !dis_ok); // R5
  AST_CHG_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!d_vld) |=> $stable(chg_ok)); // R6
  AST_DIS_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!d_vld) |=> $stable(dis_ok)); // R6
  AST_STAGE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |=> d_vld); // R8
endmodule

bind thermal_window_mon tmon_chk #(.CODE_W(CODE_W)) u_chk (.*);

// File: tb/thermal_window_mon_tb.sv
module thermal_window_mon_tb;
  localparam int W = 12;
  localparam int CS = 3000, CG = 2800, HG = 1200, HS = 1000;
  localparam int DC = 3600, DH = 600;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic s_valid = 1'b0;
  logic s_ready;
  logic [W-1:0] hi = '0, gnd = '0;
  logic chg_ok, dis_ok;

  int n_chk = 0, n_fail = 0;
  bit ref_chg = 1'b0, ref_dis = 1'b0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  thermal_window_mon #(.CODE_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_ref_hi_code(hi), .s_ref_gnd_code(gnd),
    .thr_chg_cold_stop(W'(CS)), .thr_chg_cold_go(W'(CG)),
    .thr_chg_hot_go(W'(HG)), .thr_chg_hot_stop(W'(HS)),
    .thr_dis_cold_stop(W'(DC)), .thr_dis_hot_stop(W'(DH)),
    .chg_ok(chg_ok), .dis_ok(dis_ok)
  );

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model(int d);
    if (ref_chg) begin
      if (d >= CS || d <= HS) ref_chg = 1'b0;
    end else if (d < CG && d > HG) ref_chg = 1'b1;
    ref_dis = (d < DC) && (d > DH);
  endtask

  task automatic put(int d);
    int h, g;
    if (d >= 0) begin g = (d * 7) % (4096 - d); h = g + d; end
    else begin h = ((-d) * 5) % (4096 + d); g = h - d; end
    hi = W'(h); gnd = W'(g);
  endtask

  task automatic one(int d, string req);
    @(negedge clk); put(d); s_valid = 1'b1;
    @(negedge clk); s_valid = 1'b0;
    @(negedge clk);
    model(d);
    check({req, " chg"}, int'(chg_ok), int'(ref_chg));
    check({req, " dis"}, int'(dis_ok), int'(ref_dis));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int seq[16];
    repeat (3) @(negedge clk);
    check("R7 chg in reset", int'(chg_ok), 0);
    check("R7 dis in reset", int'(dis_ok), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R7 chg after reset", int'(chg_ok), 0);
    check("R7 dis after reset", int'(dis_ok), 0);
    check("R8 ready", int'(s_ready), 1);

    // R4: start in restart gap cold side, must not enable
    one(2900, "R4 gap no start");
    one(2000, "R4 mid start");
    one(2999, "R3 below cold stop");
    one(3000, "R2 at cold stop");
    one(2800, "R4 at cold go");
    one(2799, "R4 inside cold go");
    one(1001, "R3 above hot stop");
    one(1000, "R3 at hot stop");
    one(1200, "R4 at hot go");
    one(1201, "R4 inside hot go");
    one(3599, "R5 below dis cold");
    one(3600, "R5 at dis cold");
    one(601, "R5 above dis hot");
    one(600, "R5 at dis hot");
    one(-5, "R1 negative diff");
    one(2000, "R1 recover");

    // R6: idle cycles with changing data are ignored
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); put((i % 2 == 0) ? 3900 : -50);
    end
    @(negedge clk); @(negedge clk);
    check("R6 chg idle", int'(chg_ok), int'(ref_chg));
    check("R6 dis idle", int'(dis_ok), int'(ref_dis));

    // R1-based sweep up and down across every limit
    for (int d = -60; d <= 3900; d += 23) one(d, "R2 sweep up");
    for (int d = 3900; d >= -60; d -= 19) one(d, "R3 sweep down");

    // R8: back-to-back stream, result k seen at the edge where k+2 is driven
    for (int i = 0; i < 16; i++) seq[i] = (i * 613 + 400) % 4000 - 50;
    for (int i = 0; i < 18; i++) begin
      @(negedge clk);
      if (i >= 2) begin
        model(seq[i-2]);
        check("R8 stream chg", int'(chg_ok), int'(ref_chg));
        check("R8 stream dis", int'(dis_ok), int'(ref_dis));
      end
      if (i < 16) begin put(seq[i]); s_valid = 1'b1; end
      else s_valid = 1'b0;
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule